// File: doc/BRIEF.md
# Tolerant Four-Level Sync Word Detector

This block sits behind a four-level symbol slicer and looks for a fixed 24-symbol sync word in the received symbol stream. Each symbol enters as a 2-bit level index together with a valid strobe. The block keeps the most recent 24 symbols in a sliding window. It scores the window against the stored sync word by adding up, position by position, how many level steps separate the received symbol from the expected one. When the score is small enough, it raises a one-cycle detect pulse.

The allowed score comes from a 2-bit tolerance field taken out of an 8-bit control byte. The field selects 0, 2, 4 or 6 steps, and the default after reset is 4. While the transmit-mode input is high, the block ignores received symbols and never reports a detection. When it leaves transmit mode it needs a fresh, full window before it can detect again.

Top module: `fsk_sync_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the window, the fill count and the edge memory, and sets the tolerance field to 2'b10 (4 steps). After reset `detect` reads 0.
- R2: The level indices 0, 1, 2 and 3 stand for +3, +1, -1 and -3. The cost of one position is the absolute difference of the received and expected indices. The score is the sum of these costs over 24 positions. Position 0 is the oldest symbol in the window and the newest is position 23. The expected symbol for position i is `SYNC_WORD[2i+1:2i]`.
- R3: A write (`ctrl_we` high) loads `ctrl_byte[5:4]` as the tolerance field. Its values 00, 01, 10 and 11 give limits of 0, 2, 4 and 6. A window matches when score <= limit.
- R4: Bits 7:6 and 3:0 of `ctrl_byte` have no effect on detection.
- R5: Detection requires at least 24 accepted strobes since reset or since `tx_mode` last fell. Fewer symbols never detect, even if the window contents happen to match.
- R6: While `tx_mode` is high, strobes are ignored, the fill count is cleared, and `detect` stays low in the following cycle.
- R7: `detect` is high for exactly one cycle. It follows the clock edge of an accepted strobe whose updated window first matches after a non-matching window.
- R8: The weighting is by distance. A single symbol three steps off costs 3, so it is rejected at a limit of 2 and accepted at a limit of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Strobe: `sym_code` holds a new symbol |
| sym_code | input | 2 | Level index of the received symbol |
| tx_mode | input | 1 | High while transmitting; detection suspended |
| ctrl_we | input | 1 | Load strobe for the control byte |
| ctrl_byte | input | 8 | Control byte; only bits 5:4 used |
| detect | output | 1 | One-cycle sync-found pulse |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that `sym_valid` counts one symbol per high cycle. Any 2-bit code counts as a valid level, so no code needs to be excluded. The bench drives all inputs on the falling edge and never writes the control byte in the same cycle as a strobe, so every frame is scored under a single, known limit. Before each frame it pulses `tx_mode` to flush the window, so no earlier symbols leak into a later score.

// File: rtl/fsk_sync_pkg.sv
package fsk_sync_pkg;

    typedef logic [1:0] lvl_t;

    localparam logic [1:0] TOL_RESET = 2'b10;

    // step distance between two level indices
    function automatic logic [1:0] lvl_dist(lvl_t a, lvl_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // tolerance field to allowed step count: 0, 2, 4, 6
    function automatic logic [2:0] tol_limit(logic [1:0] field);
        return {field, 1'b0};
    endfunction

endpackage

// File: rtl/fsk_sym_window.sv
module fsk_sym_window #(
    parameter int N = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           shift_en,
    input  logic [1:0]     code_in,
    output logic [N*2-1:0] win_nx,
    output logic           full_nx
);
    localparam int CNT_W = $clog2(N + 1);

    typedef struct packed {
        logic [N*2-1:0] win;
        logic [CNT_W-1:0] fill;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.fill = '0;
        end else if (shift_en) begin
            // newest symbol enters at the top, oldest leaves from bits 1:0
            st_d.win = {code_in, st_q.win[N*2-1:2]};
            if (st_q.fill != CNT_W'(N))
                st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_nx  = st_d.win;
    assign full_nx = (st_d.fill == CNT_W'(N));

endmodule

// File: rtl/fsk_dist_sum.sv
module fsk_dist_sum
    import fsk_sync_pkg::*;
#(
    parameter int N = 24,
    parameter logic [N*2-1:0] SYNC_WORD = '0,
    localparam int SCORE_W = $clog2(3 * N + 1)
) (
    input  logic [N*2-1:0]   win,
    output logic [SCORE_W-1:0] score
);
    logic [1:0] cost [N];

    for (genvar i = 0; i < N; i++) begin : g_pos
        assign cost[i] = lvl_dist(win[2*i +: 2], SYNC_WORD[2*i +: 2]);
    end

    always_comb begin
        score = '0;
        for (int i = 0; i < N; i++)
            score = score + SCORE_W'(cost[i]);
    end

endmodule

// File: rtl/fsk_sync_detect.sv
module fsk_sync_detect
    import fsk_sync_pkg::*;
#(
    parameter int N = 24,
    parameter logic [N*2-1:0] SYNC_WORD = 48'h3A5C961E7B24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_valid,
    input  logic [1:0] sym_code,
    input  logic       tx_mode,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_byte,
    output logic       detect
);
    localparam int SCORE_W = $clog2(3 * N + 1);

    typedef struct packed {
        logic [1:0] tol;
        logic       armed;
        logic       det;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N*2-1:0]     win_nx;
    logic               full_nx;
    logic [SCORE_W-1:0] score;
    logic               accept;
    logic               match;
    logic               ctrl_unused;

    assign ctrl_unused = ^{ctrl_byte[7:6], ctrl_byte[3:0]};
    assign accept      = sym_valid & ~tx_mode;

    fsk_sym_window #(.N(N)) u_window (
        .clk      (clk),
        .rst      (rst),
        .clear    (tx_mode),
        .shift_en (accept),
        .code_in  (sym_code),
        .win_nx   (win_nx),
        .full_nx  (full_nx)
    );

    fsk_dist_sum #(.N(N), .SYNC_WORD(SYNC_WORD)) u_score (
        .win   (win_nx),
        .score (score)
    );

    assign match = full_nx && (score <= SCORE_W'(tol_limit(st_q.tol)));

    always_comb begin
        st_d     = st_q;
        st_d.det = 1'b0;
        if (tx_mode) begin
            st_d.armed = 1'b0;
        end else if (accept) begin
            st_d.det   = match & ~st_q.armed;
            st_d.armed = match;
        end
        if (ctrl_we)
            st_d.tol = ctrl_byte[5:4];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tol   <= TOL_RESET;
            st_q.armed <= 1'b0;
            st_q.det   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign detect = st_q.det;

endmodule

// File: rtl/fsk_sync_detect_chk.sv
module fsk_sync_detect_chk #(
    parameter int N = 24
) (
    input logic clk,
    input logic rst,
    input logic sym_valid,
    input logic tx_mode,
    input logic detect
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || tx_mode)
            seen_q <= '0;
        else if (sym_valid && seen_q != CW'(N))
            seen_q <= seen_q + 1'b1;
    end

    // R1: cycle after reset shows no detect
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !detect);

    // R5: enough symbols since reset / transmit exit
    a_r5_window_filled: assert property (@(posedge clk) disable iff (rst)
        detect |-> (seen_q == CW'(N)));

    // R6: transmit mode blocks detection
    a_r6_tx_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(tx_mode) |-> !detect);

    // R7: one-cycle pulse following a strobe
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

    a_r7_after_strobe: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(sym_valid));

endmodule

bind fsk_sync_detect fsk_sync_detect_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .tx_mode   (tx_mode),
    .detect    (detect)
);

// File: tb/tb_fsk_sync_detect.sv
module tb_fsk_sync_detect;
    localparam int N = 24;
    localparam logic [47:0] PAT = 48'h3A5C961E7B24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_code = 2'b00;
    logic       tx_mode = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_byte = 8'h00;
    logic       detect;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fsk_sync_detect #(.N(N), .SYNC_WORD(PAT)) dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_code(sym_code),
        .tx_mode(tx_mode), .ctrl_we(ctrl_we), .ctrl_byte(ctrl_byte),
        .detect(detect)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] pat_sym(input int i);
        return PAT[2*i +: 2];
    endfunction

    task automatic send(input logic [1:0] c, output bit got);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = c;
        @(negedge clk);
        sym_valid = 1'b0;
        got = detect;
    endtask

    task automatic write_ctrl(input logic [7:0] b);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_byte = b;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        tx_mode = 1'b1;
        @(negedge clk);
        tx_mode = 1'b0;
    endtask

    // sends the sync word with `cost` single-step errors, or one 3-step error at position 0
    task automatic frame(input int cost, input bit big, output bit early, output bit last);
        bit g;
        early = 1'b0;
        last = 1'b0;
        flush();
        for (int i = 0; i < N; i++) begin
            logic [1:0] c;
            c = pat_sym(i);
            if (big && i == 0) c = 2'd3 - c;
            else if (i < cost) c = (c >= 2) ? c - 2'd1 : c + 2'd1;
            send(c, g);
            if (i < N - 1) early |= g; else last = g;
        end
    endtask

    task automatic t_reset();
        bit e, l;
        check(detect == 1'b0, "R1 detect low after reset", detect, 0);
        frame(4, 1'b0, e, l);
        check(l == 1'b1, "R1 default limit accepts 4", l, 1);
        frame(5, 1'b0, e, l);
        check(l == 1'b0, "R1 default limit rejects 5", l, 0);
    endtask

    task automatic t_exact();
        bit e, l, g;
        write_ctrl(8'h00);
        frame(0, 1'b0, e, l);
        check(l == 1'b1, "R2 exact word detected at limit 0", l, 1);
        check(e == 1'b0, "R5 no detect before 24 symbols", e, 0);
        @(negedge clk);
        g = detect;
        check(g == 1'b0, "R7 pulse lasts one cycle", g, 0);
    endtask

    task automatic t_limits();
        bit e, l;
        for (int f = 0; f < 4; f++) begin
            write_ctrl(8'(f << 4));
            frame(2 * f, 1'b0, e, l);
            check(l == 1'b1, "R3 score at limit accepted", l, 1);
            frame(2 * f + 1, 1'b0, e, l);
            check(l == 1'b0, "R3 score above limit rejected", l, 0);
        end
    endtask

    task automatic t_ignored_bits();
        bit e, l;
        write_ctrl(8'hDF);
        frame(2, 1'b0, e, l);
        check(l == 1'b1, "R4 other bits ignored, limit 2 accepts", l, 1);
        frame(3, 1'b0, e, l);
        check(l == 1'b0, "R4 other bits ignored, limit 2 rejects 3", l, 0);
    endtask

    task automatic t_weight();
        bit e, l;
        write_ctrl(8'h10);
        frame(0, 1'b1, e, l);
        check(l == 1'b0, "R8 3-step symbol rejected at limit 2", l, 0);
        write_ctrl(8'h20);
        frame(0, 1'b1, e, l);
        check(l == 1'b1, "R8 3-step symbol accepted at limit 4", l, 1);
    endtask

    task automatic t_fill();
        bit g, any;
        any = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // zeroed window already holds pattern symbol 0; send the other 23
        for (int i = 1; i < N; i++) begin
            send(pat_sym(i), g);
            any |= g;
        end
        check(any == 1'b0, "R5 matching but unfilled window silent", any, 0);
    endtask

    task automatic t_tx();
        bit g, any, e, l;
        any = 1'b0;
        @(negedge clk);
        tx_mode = 1'b1;
        for (int i = 0; i < N; i++) begin
            send(pat_sym(i), g);
            any |= g;
        end
        check(any == 1'b0, "R6 no detect in transmit mode", any, 0);
        @(negedge clk);
        tx_mode = 1'b0;
        any = 1'b0;
        for (int i = 1; i < N; i++) begin
            send(pat_sym(i), g);
            any |= g;
        end
        check(any == 1'b0, "R6 tx strobes not counted toward fill", any, 0);
        frame(0, 1'b0, e, l);
        check(l == 1'b1, "R6 detection resumes after transmit", l, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact();
        t_limits();
        t_ignored_bits();
        t_weight();
        t_fill();
        t_tx();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule